// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible face of a small platform interrupt controller that serves 31 interrupt sources (IDs 1 to 31; ID 0 means "no interrupt") and two target contexts. A host reaches it through a 32-bit word bus. Through that bus the host sets a 3-bit priority for each source, an enable mask for each context and a 3-bit threshold for each context. It can also read the pending bits, which are read-only. The gateways in front of the block raise pending bits with one-cycle request pulses. The block holds those pending bits. Each context gets its own priority arbiter, built as a submodule, which picks that context's winning source.

Each context has a claim/complete word, and access to it has side effects. A read returns the winning ID of that context and clears the winner's pending bit in the same step. A write takes the written value as a completed ID and sends a one-cycle completion pulse to that source's gateway, but only when the source is enabled for the context that was written. Each context also has an interrupt line. The line is high while the best pending, enabled source of that context has a priority strictly greater than the context's threshold.

The bus works one transaction at a time. A request is accepted in a cycle where `bus_req` is high and `bus_ready` is low. All register updates and side effects take place at that clock edge. In the next cycle `bus_ready` is high for exactly one cycle and `bus_rdata` carries the read result. A request that is still held during the ready cycle is not accepted a second time.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset, all priorities, enables, thresholds and pending bits are zero, and `bus_ready`, `bus_rdata`, `gw_done` and `ctx_irq` are zero.
- R2: A request seen with `bus_ready` low is accepted. `bus_ready` is then high in the next cycle only, and a request still held in that cycle is not accepted again.
- R3: The priority of source N is at byte offset 4·N. Only bits 2:0 can be written, any value in those bits is legal, and bits 31:3 read as zero. The word at offset 0 (ID 0) reads as zero and ignores writes.
- R4: The pending word at offset 0x1000 holds source N in bit N, and bit 0 is always zero. A pulse on `gw_req[N]` sets bit N at the next edge. Bus writes to this word have no effect.
- R5: The enable word of context c is at 0x2000 + 0x80·c, with source N in bit N. Bit 0 reads as zero whatever was written.
- R6: The threshold of context c is at 0x200000 + 0x1000·c. Only bits 2:0 are kept and the upper bits read as zero.
- R7: `ctx_irq[c]` is high exactly when some pending source enabled for c has a priority strictly greater than the threshold of c.
- R8: A read of claim/complete at threshold address + 4 returns the ID of the pending, enabled source of that context with the highest nonzero priority, the lowest ID winning ties. The threshold does not affect it. The read returns 0 when no such source exists.
- R9: An accepted claim read clears the pending bit of the returned ID. A write to the claim/complete word clears no pending bit.
- R10: A write of ID N (1 to 31) to the claim/complete word of context c, with N enabled for c, pulses `gw_done[N]` for one cycle, namely the cycle after acceptance. This happens whether or not N was the last claimed ID.
- R11: A completion write whose value is 0, is above 31, or names a source not enabled for that context produces no `gw_done` pulse.
- R12: Unmapped and reserved offsets read as zero and ignore writes. These include priorities above ID 31, offset 0x1004, enable space beyond one word per context or beyond context 1, context offsets other than +0 and +4, and context 2 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Transaction request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 26 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle response strobe |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| gw_req | input | 31 | Gateway request pulses, bit N for source N (indices 31:1) |
| gw_done | output | 31 | Completion pulses to gateways, bit N for source N (indices 31:1) |
| ctx_irq | output | 2 | Interrupt notification per context |

## Verification
The bench targets the corner cases of the claim path. Tied priorities check the ID order: reversing it would return source 2 ahead of source 1. A source with priority zero must never be claimed. A claim on a context whose only source lies under the threshold must still succeed, and a design that gated claims by threshold would return 0 there. A completion value of 33 must not be truncated to ID 1, and a completion write must not clear a pending bit, since a design that decoded claim/complete without the read direction would lose the interrupt. The WARL masking, hardwired bit 0 and reserved holes are read back after writes of all ones, so stray bits or aliasing into a neighbouring register show up as miscompares.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Fixed layout of the register space (byte offsets)
  localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CC
  } reg_kind_e;

  // Number of 32-bit words needed for bits 0..nsrc
  function automatic int unsigned words_for(input int unsigned nsrc);
    return (nsrc + 32) / 32;
  endfunction

  function automatic logic [31:0] prio_addr(input int unsigned id);
    return PRIO_BASE + 32'(id) * 32'd4;
  endfunction

  function automatic logic [31:0] en_addr(input int unsigned ctx, input int unsigned word);
    return EN_BASE + 32'(ctx) * EN_STRIDE + 32'(word) * 32'd4;
  endfunction

  function automatic logic [31:0] thr_addr(input int unsigned ctx);
    return CTX_BASE + 32'(ctx) * CTX_STRIDE;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int ID_W   = 5,
  parameter int CTX_W  = 1,
  parameter int WSEL_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [ID_W-1:0]   id,
  output logic [CTX_W-1:0]  ctx,
  output logic [WSEL_W-1:0] wsel
);
  localparam int unsigned NWORD = words_for(NSRC);

  logic [31:0] a;
  logic [31:0] off;
  logic [31:0] word_idx;

  always_comb begin
    a        = {32'(addr) >> 2, 2'b00};
    kind     = RG_NONE;
    id       = '0;
    ctx      = '0;
    wsel     = '0;
    off      = '0;
    word_idx = a >> 2;
    if (a < PEND_BASE) begin
      if (word_idx >= 32'd1 && word_idx <= 32'(NSRC)) begin
        kind = RG_PRIO;
        id   = ID_W'(word_idx);
      end
    end else if (a < PEND_BASE + 32'(NWORD) * 32'd4) begin
      off  = a - PEND_BASE;
      kind = RG_PEND;
      wsel = WSEL_W'(off >> 2);
    end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * 32'(NCTX)) begin
      off = a - EN_BASE;
      ctx = CTX_W'(off / EN_STRIDE);
      if (((off % EN_STRIDE) >> 2) < 32'(NWORD)) begin
        kind = RG_EN;
        wsel = WSEL_W'((off % EN_STRIDE) >> 2);
      end
    end else if (a >= CTX_BASE && a < CTX_BASE + CTX_STRIDE * 32'(NCTX)) begin
      off = a - CTX_BASE;
      ctx = CTX_W'(off / CTX_STRIDE);
      if ((off % CTX_STRIDE) == 32'd0)      kind = RG_THR;
      else if ((off % CTX_STRIDE) == 32'd4) kind = RG_CC;
    end
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC:1]             cand,
  input  logic [NSRC:1][PRIO_W-1:0] prio,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  // Ascending scan with strict compare: lowest ID keeps a tie,
  // and priority zero can never beat the initial zero.
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (cand[i] && prio[i] > best_prio) begin
        best_prio = prio[i];
        best_id   = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_bank_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC:1]     gw_req,
  output logic [NSRC:1]     gw_done,
  output logic [NCTX-1:0]   ctx_irq
);
  localparam int ID_W   = $clog2(NSRC + 1);
  localparam int NWORD  = int'(words_for(NSRC));
  localparam int PAD_W  = NWORD * 32;
  localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int WSEL_W = (NWORD > 1) ? $clog2(NWORD) : 1;

  // Architectural state
  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [NSRC:1]             ip_q;
  logic [NCTX-1:0][NSRC:1]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic                      ready_q;
  logic [31:0]               rdata_q;
  logic [NSRC:1]             done_q;

  // Named internal events
  logic          acc, wr, rd;
  reg_kind_e     dec_kind;
  logic [ID_W-1:0]   dec_id;
  logic [CTX_W-1:0]  dec_ctx;
  logic [WSEL_W-1:0] dec_wsel;
  logic [NCTX-1:0]   claim_fire;
  logic [ID_W-1:0]   claim_id;
  logic [NSRC:1]     claim_clr;
  logic              cmpl_ok;
  logic              cmpl_drop;
  logic [ID_W-1:0]   cmpl_id;
  logic [NSRC:1]     cmpl_vec;

  logic [NCTX-1:0][ID_W-1:0]   win_id;
  logic [NCTX-1:0][PRIO_W-1:0] win_prio;

  logic [PAD_W-1:0]            ip_pad;
  logic [NCTX-1:0][PAD_W-1:0]  en_pad;
  logic [PAD_W-1:0]            en_wr_pad;
  logic [31:0]                 rv;

  assign acc = bus_req & ~ready_q;
  assign wr  = acc & bus_we;
  assign rd  = acc & ~bus_we;

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX),
    .ID_W(ID_W), .CTX_W(CTX_W), .WSEL_W(WSEL_W)
  ) u_dec (
    .addr (bus_addr),
    .kind (dec_kind),
    .id   (dec_id),
    .ctx  (dec_ctx),
    .wsel (dec_wsel)
  );

  // Word images with bit 0 (non-existent source) fixed at zero
  always_comb begin
    ip_pad = '0;
    ip_pad[NSRC:1] = ip_q;
    for (int c = 0; c < NCTX; c++) begin
      en_pad[c] = '0;
      en_pad[c][NSRC:1] = en_q[c];
    end
  end

  // One arbiter per context; notification compares against threshold
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irq_prio_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand      (ip_q & en_q[c]),
      .prio      (prio_q),
      .best_id   (win_id[c]),
      .best_prio (win_prio[c])
    );
    assign ctx_irq[c]    = win_prio[c] > thr_q[c];
    assign claim_fire[c] = rd && (dec_kind == RG_CC) && (dec_ctx == CTX_W'(c));
  end

  assign claim_id = win_id[dec_ctx];

  always_comb begin
    claim_clr = '0;
    if (|claim_fire) begin
      for (int i = 1; i <= NSRC; i++) begin
        claim_clr[i] = (claim_id == ID_W'(i));
      end
    end
  end

  // Completion: value must name an existing source enabled for the context
  assign cmpl_id = ID_W'(bus_wdata);
  always_comb begin
    cmpl_ok  = 1'b0;
    cmpl_vec = '0;
    if (wr && dec_kind == RG_CC && bus_wdata != 32'd0 && bus_wdata <= 32'(NSRC)) begin
      cmpl_ok = en_pad[dec_ctx][cmpl_id];
    end
    if (cmpl_ok) begin
      for (int i = 1; i <= NSRC; i++) begin
        cmpl_vec[i] = (cmpl_id == ID_W'(i));
      end
    end
  end
  assign cmpl_drop = wr && (dec_kind == RG_CC) && !cmpl_ok;

  // Read mux
  always_comb begin
    unique case (dec_kind)
      RG_PRIO: rv = 32'(prio_q[dec_id]);
      RG_PEND: rv = ip_pad[32'(dec_wsel) * 32 +: 32];
      RG_EN:   rv = en_pad[dec_ctx][32'(dec_wsel) * 32 +: 32];
      RG_THR:  rv = 32'(thr_q[dec_ctx]);
      RG_CC:   rv = 32'(claim_id);
      default: rv = 32'd0;
    endcase
  end

  // Enable write merge into the addressed word
  always_comb begin
    en_wr_pad = en_pad[dec_ctx];
    en_wr_pad[32'(dec_wsel) * 32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      ip_q    <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      ready_q <= 1'b0;
      rdata_q <= '0;
      done_q  <= '0;
    end else begin
      ready_q <= acc;
      rdata_q <= rd ? rv : 32'd0;
      done_q  <= cmpl_vec;
      ip_q    <= (ip_q & ~claim_clr) | gw_req;
      if (wr) begin
        unique case (dec_kind)
          RG_PRIO: prio_q[dec_id] <= bus_wdata[PRIO_W-1:0];
          RG_EN:   en_q[dec_ctx]  <= en_wr_pad[NSRC:1];
          RG_THR:  thr_q[dec_ctx] <= bus_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;
  assign gw_done   = done_q;

endmodule

// File: rtl/irq_reg_bank_chk.sv
module irq_reg_bank_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_ready,
  input logic [NSRC:1]   gw_req,
  input logic [NSRC:1]   gw_done,
  input logic [NCTX-1:0] ctx_irq,
  input logic [NSRC:1]   ip_q,
  input logic [NCTX-1:0] claim_fire,
  input logic [NSRC:1]   claim_clr,
  input logic            cmpl_drop
);

  // R2
  accept_gives_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> bus_ready);

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R10
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gw_done));

  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gw_done) |-> $past(bus_req && !bus_ready && bus_we));

  // R11
  drop_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_drop |=> (gw_done == '0));

  // R9
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(claim_clr & ~gw_req)) |=> ((ip_q & $past(claim_clr & ~gw_req)) == '0));

  // R4
  ip_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_req == '0 && claim_clr == '0) |=> $stable(ip_q));

  // R8
  claim_one_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_fire));

  // R7
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_irq != '0) |-> (ip_q != '0));

endmodule

bind irq_reg_bank irq_reg_bank_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_ready  (bus_ready),
  .gw_req     (gw_req),
  .gw_done    (gw_done),
  .ctx_irq    (ctx_irq),
  .ip_q       (ip_q),
  .claim_fire (claim_fire),
  .claim_clr  (claim_clr),
  .cmpl_drop  (cmpl_drop)
);

// File: tb/tb_irq_reg_bank.sv
`timescale 1ns/100ps
module tb_irq_reg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [25:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [31:1] gw_req = '0;
  logic [31:1] gw_done;
  logic [1:0]  ctx_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_reg_bank dut (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .gw_req(gw_req), .gw_done(gw_done), .ctx_irq(ctx_irq)
  );

  typedef struct packed {
    logic        we;
    logic [25:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 26'h0000004, 32'h0,        32'h0,        4'd1},  // R1 priority
    '{1'b0, 26'h0200000, 32'h0,        32'h0,        4'd1},  // R1 threshold
    '{1'b0, 26'h0002080, 32'h0,        32'h0,        4'd1},  // R1 enable
    '{1'b0, 26'h0001000, 32'h0,        32'h0,        4'd1},  // R1 pending
    '{1'b1, 26'h0000004, 32'hFFFF_FFFD,32'h0,        4'd3},  // R3
    '{1'b0, 26'h0000004, 32'h0,        32'h5,        4'd3},  // R3 WARL
    '{1'b1, 26'h0000000, 32'h7,        32'h0,        4'd3},  // R3 ID 0
    '{1'b0, 26'h0000000, 32'h0,        32'h0,        4'd3},  // R3
    '{1'b1, 26'h000007C, 32'h2,        32'h0,        4'd3},  // R3 ID 31
    '{1'b0, 26'h000007C, 32'h0,        32'h2,        4'd3},  // R3
    '{1'b1, 26'h0000080, 32'h7,        32'h0,        4'd12}, // R12 ID 32
    '{1'b0, 26'h0000080, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b1, 26'h0002000, 32'hFFFF_FFFF,32'h0,        4'd5},  // R5
    '{1'b0, 26'h0002000, 32'h0,        32'hFFFF_FFFE,4'd5},  // R5 bit 0
    '{1'b1, 26'h0002080, 32'h0000_000B,32'h0,        4'd5},  // R5 ctx 1
    '{1'b0, 26'h0002080, 32'h0,        32'h0000_000A,4'd5},  // R5
    '{1'b1, 26'h0200000, 32'hFFFF_FFF9,32'h0,        4'd6},  // R6
    '{1'b0, 26'h0200000, 32'h0,        32'h1,        4'd6},  // R6 WARL
    '{1'b1, 26'h0201000, 32'h4,        32'h0,        4'd6},  // R6 ctx 1
    '{1'b0, 26'h0201000, 32'h0,        32'h4,        4'd6},  // R6
    '{1'b1, 26'h0200008, 32'h5,        32'h0,        4'd12}, // R12 reserved
    '{1'b0, 26'h0200008, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 26'h0001004, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 26'h0002100, 32'h0,        32'h0,        4'd12}, // R12 ctx 2
    '{1'b0, 26'h0202000, 32'h0,        32'h0,        4'd12}, // R12 ctx 2
    '{1'b1, 26'h0002004, 32'hFFFF_FFFF,32'h0,        4'd12}, // R12 word 1
    '{1'b0, 26'h0002004, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 26'h0002080, 32'h0,        32'h0000_000A,4'd12}, // R12 no alias
    '{1'b1, 26'h0001000, 32'hFFFF_FFFF,32'h0,        4'd4},  // R4 read-only
    '{1'b0, 26'h0001000, 32'h0,        32'h0,        4'd4},  // R4
    '{1'b0, 26'h0200004, 32'h0,        32'h0,        4'd8}   // R8 empty claim
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus transaction; returns read data and completion pulses (bit N = source N)
  task automatic xfer(input logic we, input logic [25:0] a, input logic [31:0] wd,
                      output logic [31:0] rdv, output logic [31:0] done);
    int n;
    bus_we = we; bus_addr = a; bus_wdata = wd; bus_req = 1'b1;
    @(negedge clk);
    n = 1;
    while (!bus_ready && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R2 ready latency", 32'(n), 32'd1);
    rdv  = bus_rdata;
    done = {gw_done, 1'b0};
    // R2: keep request through the ready cycle; must not be re-accepted
    @(negedge clk);
    chk("R2 ready drops", {31'd0, bus_ready}, 32'd0);
    chk("R10 done one cycle", {gw_done, 1'b0}, 32'd0);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] wd);
    logic [31:0] r, d;
    xfer(1'b1, a, wd, r, d);
  endtask

  task automatic rd_chk(input string tag, input logic [25:0] a, input logic [31:0] exp);
    logic [31:0] r, d;
    xfer(1'b0, a, 32'd0, r, d);
    chk(tag, r, exp);
  endtask

  task automatic cmpl_chk(input string tag, input logic [25:0] a, input logic [31:0] id,
                          input logic [31:0] exp_done);
    logic [31:0] r, d;
    xfer(1'b1, a, id, r, d);
    chk(tag, d, exp_done);
  endtask

  task automatic gw_pulse(input logic [31:0] m);
    @(negedge clk);
    gw_req = m[31:1];
    @(negedge clk);
    gw_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 outputs after reset
    chk("R1 ready", {31'd0, bus_ready}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 done", {gw_done, 1'b0}, 32'd0);
    chk("R1 irq", 32'(ctx_irq), 32'd0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].we, VEC[i].addr, VEC[i].wd, r, d);
      if (!VEC[i].we) chk($sformatf("R%0d vec%0d", VEC[i].rq, i), r, VEC[i].exp);
    end

    // Setup: prio id1=3 id2=3 id5=6 id9=0 id31=2; en0=all, en1={2,9}; thr0=1 thr1=3
    wr(26'h0000004, 32'd3);
    wr(26'h0000008, 32'd3);
    wr(26'h0000014, 32'd6);
    wr(26'h0000024, 32'd0);
    wr(26'h0002080, 32'h0000_0204);
    wr(26'h0201000, 32'd3);

    gw_pulse(32'h8000_0206);
    rd_chk("R4 pending bits", 26'h0001000, 32'h8000_0206);
    chk("R7 irq ctx0 on, ctx1 at threshold", 32'(ctx_irq), 32'd1);

    rd_chk("R8 tie lowest id", 26'h0200004, 32'd1);
    rd_chk("R9 claim cleared", 26'h0001000, 32'h8000_0204);
    rd_chk("R8 threshold ignored", 26'h0201004, 32'd2);
    rd_chk("R9 claim cleared 2", 26'h0001000, 32'h8000_0200);
    rd_chk("R8 prio zero not claimable", 26'h0201004, 32'd0);
    rd_chk("R9 empty claim clears nothing", 26'h0001000, 32'h8000_0200);
    chk("R7 irq after claims", 32'(ctx_irq), 32'd1);

    gw_pulse(32'h0000_0020);
    chk("R7 irq source 5", 32'(ctx_irq), 32'd1);
    wr(26'h0200000, 32'd6);
    chk("R7 prio equal threshold masked", 32'(ctx_irq), 32'd0);
    wr(26'h0200000, 32'd5);
    chk("R7 prio above threshold", 32'(ctx_irq), 32'd1);
    wr(26'h0200000, 32'd1);

    rd_chk("R8 highest prio", 26'h0200004, 32'd5);
    rd_chk("R8 next prio", 26'h0200004, 32'd31);
    rd_chk("R8 nothing left", 26'h0200004, 32'd0);
    rd_chk("R9 pending left", 26'h0001000, 32'h0000_0200);

    gw_pulse(32'h0000_0002);
    cmpl_chk("R10 completion id 1", 26'h0200004, 32'd1, 32'h0000_0002);
    rd_chk("R9 write does not claim", 26'h0001000, 32'h0000_0202);
    rd_chk("R8 claim after write", 26'h0200004, 32'd1);

    cmpl_chk("R10 unclaimed id accepted", 26'h0200004, 32'd7, 32'h0000_0080);
    cmpl_chk("R10 ctx1 enabled id", 26'h0201004, 32'd2, 32'h0000_0004);
    cmpl_chk("R11 ctx1 not enabled", 26'h0201004, 32'd1, 32'd0);
    cmpl_chk("R11 id zero", 26'h0200004, 32'd0, 32'd0);
    cmpl_chk("R11 id 32", 26'h0200004, 32'd32, 32'd0);
    cmpl_chk("R11 id 33 no wrap", 26'h0200004, 32'd33, 32'd0);

    wr(26'h0001000, 32'd0);
    rd_chk("R4 pending write ignored", 26'h0001000, 32'h0000_0200);
    rd_chk("R12 reserved after activity", 26'h020000C, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule